// File: doc/BRIEF.md
# Dot-Product Coprocessor

This block is a coprocessor that sits on a processor's data bus. It computes the dot product of two arrays of 32-bit integers that are held in a data memory it shares with the processor. Software sees a small window of word registers: a base address for each array, an element count, a control/status word and a result word. Software loads the three arguments, then writes 1 to the control word to launch the job. The coprocessor then reads both arrays itself through its own memory master port and feeds each fetched pair into a multiply-accumulate pipeline.

Software usually reads the result word right after the launch. While the job runs, that read is held off (slave ready low) and completes once the final sum has been stored. Both ports use a single-word valid/ready handshake. A master read returns its data in the same cycle as the handshake.

The sequencer in `dotp_fetch` has four states. IDLE waits for a launch. FETCH_A reads the next element of the first array. FETCH_B reads the matching element of the second array. DRAIN waits for the multiply-accumulate pipeline to empty. The transitions are:
- IDLE to FETCH_A on a launch with a nonzero count.
- IDLE to DRAIN on a launch with a zero count.
- FETCH_A to FETCH_B on a master handshake.
- FETCH_B to FETCH_A on a handshake when pairs remain.
- FETCH_B to DRAIN on the handshake of the last pair.
- DRAIN to IDLE once the pipeline is empty. This step is the finish event, which stores the result and sets the done flag.

Top module: `dotp_accel`

## Requirements
- R1: The window sits at base 0xF000_0000 (parameter WIN_BASE), with 32 bytes decoded. The word offsets are: 0x00 result, 0x08 control/status, 0x0C first-array base, 0x10 second-array base, 0x14 element count. The three argument words read back what was last written. Other offsets in the window read as 0 and ignore writes.
- R2: A write to the control word with bit 0 set, accepted while idle, launches a job. A control write with bit 0 clear launches nothing.
- R3: The result is the sum over i < N of A[i]*B[i]. Element i of an array is at base + 4*i. Products and the running sum wrap modulo 2^32.
- R4: The master reads element i of the first array, then element i of the second array, through one port in ascending i. While m_ready is low, the master keeps m_valid high and m_addr unchanged.
- R5: With a memory that is always ready, the final sum is stored within 2*N+4 cycles of the launch edge. This lets a result read launched right after the launch complete at or before edge 2*N+4.
- R6: A result read while a job runs holds s_ready low until the sum is stored, and then returns it. A result read while idle completes in its first cycle with the last stored sum.
- R7: A job with N = 0 gives result 0 and issues no master access.
- R8: The control/status word reads bit 0 = busy and bit 1 = done, with the other bits 0. A launch clears done, and the finish event sets it.
- R9: Control writes accepted while busy are ignored. The running job keeps its original arguments and its result.
- R10: After reset the status word reads 0, the result reads 0 and m_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Slave request valid |
| s_write | input | 1 | Slave request is a write |
| s_addr | input | 32 | Slave byte address |
| s_wdata | input | 32 | Slave write data |
| s_ready | output | 1 | Slave accepts the request this cycle |
| s_rdata | output | 32 | Slave read data, valid with s_ready |
| m_valid | output | 1 | Master read request |
| m_addr | output | 32 | Master byte address |
| m_ready | input | 1 | Memory accepts the read this cycle |
| m_rdata | input | 32 | Memory read data for the accepted read |

## Verification
The bench goes after the following corner cases, and each one shows up a specific kind of broken design:
- Zero-length jobs. A broken design would issue memory reads or keep a stale sum.
- Operands near the signed extremes. A design that saturates or widens the sum would return a value that differs from the wrapped one.
- Memory stalls. A design that drops its request or moves the address during a stall would fetch the wrong elements.
- A launch attempt in mid-job. A design that restarts would return a sum over the new count.
- Idle result reads and reads made right after a launch. A design that mishandles the read hold-off would return a partial sum, or would stall when it should answer at once.

The fetch order is also checked address by address, so that a design that swaps the arrays or skips an element is caught even when the sum happens to agree.

// File: rtl/dotp_pkg.sv
package dotp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH_A,
        ST_FETCH_B,
        ST_DRAIN
    } fetch_state_t;

    localparam int WIN_BITS = 5;
    localparam logic [WIN_BITS-1:0] OFS_RESULT = 5'h00;
    localparam logic [WIN_BITS-1:0] OFS_CTRL   = 5'h08;
    localparam logic [WIN_BITS-1:0] OFS_SRC_A  = 5'h0C;
    localparam logic [WIN_BITS-1:0] OFS_SRC_B  = 5'h10;
    localparam logic [WIN_BITS-1:0] OFS_LEN    = 5'h14;
endpackage

// File: rtl/dotp_mac.sv
module dotp_mac #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          in_valid,
    input  logic [DW-1:0] in_a,
    input  logic [DW-1:0] in_b,
    output logic [DW-1:0] acc,
    output logic          busy
);
    logic [DW-1:0] prod_q;
    logic          prod_v;

    // stage 1: product, truncated to the word width (wraps like C int)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_q <= '0;
            prod_v <= 1'b0;
        end else begin
            prod_v <= in_valid;
            if (in_valid) prod_q <= in_a * in_b;
        end
    end

    // stage 2: running sum
    always_ff @(posedge clk) begin
        if (!rst_n)      acc <= '0;
        else if (clear)  acc <= '0;
        else if (prod_v) acc <= acc + prod_q;
    end

    assign busy = prod_v;

    // R3: a cleared accumulator starts the job at zero
    p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clear && !in_valid && !prod_v |=> acc == '0);
endmodule

// File: rtl/dotp_fetch.sv
module dotp_fetch
    import dotp_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] base_a,
    input  logic [AW-1:0] base_b,
    input  logic [CW-1:0] count,
    output logic          m_valid,
    output logic [AW-1:0] m_addr,
    input  logic          m_ready,
    input  logic [DW-1:0] m_rdata,
    output logic          pair_valid,
    output logic [DW-1:0] pair_a,
    output logic [DW-1:0] pair_b,
    input  logic          pipe_busy,
    output logic          busy,
    output logic          finish
);
    localparam int STEP = DW / 8;

    fetch_state_t  state_q, state_d;
    logic [AW-1:0] ptr_a, ptr_b;
    logic [CW-1:0] left_q;
    logic [DW-1:0] hold_a;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start) state_d = (count == '0) ? ST_DRAIN : ST_FETCH_A;
            ST_FETCH_A: if (m_ready) state_d = ST_FETCH_B;
            ST_FETCH_B: if (m_ready) state_d = (left_q == CW'(1)) ? ST_DRAIN : ST_FETCH_A;
            ST_DRAIN:   if (!pair_valid && !pipe_busy) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_a      <= '0;
            ptr_b      <= '0;
            left_q     <= '0;
            hold_a     <= '0;
            pair_valid <= 1'b0;
            pair_a     <= '0;
            pair_b     <= '0;
        end else begin
            pair_valid <= 1'b0;
            if (state_q == ST_IDLE && start) begin
                ptr_a  <= base_a;
                ptr_b  <= base_b;
                left_q <= count;
            end
            if (state_q == ST_FETCH_A && m_ready) begin
                hold_a <= m_rdata;
                ptr_a  <= ptr_a + AW'(STEP);
            end
            if (state_q == ST_FETCH_B && m_ready) begin
                pair_valid <= 1'b1;
                pair_a     <= hold_a;
                pair_b     <= m_rdata;
                ptr_b      <= ptr_b + AW'(STEP);
                left_q     <= left_q - CW'(1);
            end
        end
    end

    always_comb begin
        m_valid = (state_q == ST_FETCH_A) || (state_q == ST_FETCH_B);
        m_addr  = (state_q == ST_FETCH_B) ? ptr_b : ptr_a;
        busy    = (state_q != ST_IDLE);
        finish  = (state_q == ST_DRAIN) && !pair_valid && !pipe_busy;
    end

    // R4: a stalled request is held steady
    p_hold_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid && !m_ready |=> m_valid && $stable(m_addr));
    // R7: memory is only touched while a job is running
    p_fetch_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> busy);
endmodule

// File: rtl/dotp_accel.sv
module dotp_accel
    import dotp_pkg::*;
#(
    parameter int              AW       = 32,
    parameter int              DW       = 32,
    parameter logic [AW-1:0]   WIN_BASE = 32'hF000_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_valid,
    input  logic          s_write,
    input  logic [AW-1:0] s_addr,
    input  logic [DW-1:0] s_wdata,
    output logic          s_ready,
    output logic [DW-1:0] s_rdata,
    output logic          m_valid,
    output logic [AW-1:0] m_addr,
    input  logic          m_ready,
    input  logic [DW-1:0] m_rdata
);
    logic [AW-1:0]       src_a, src_b;
    logic [DW-1:0]       len_q, result_q, acc;
    logic                done_q, busy, finish, start, wr_ok, hit, rd_result;
    logic                pair_valid, pipe_busy;
    logic [DW-1:0]       pair_a, pair_b;
    logic [WIN_BITS-1:0] off;

    assign hit       = (s_addr[AW-1:WIN_BITS] == WIN_BASE[AW-1:WIN_BITS]);
    assign off       = s_addr[WIN_BITS-1:0];
    assign rd_result = s_valid && !s_write && hit && (off == OFS_RESULT);
    assign s_ready   = !(rd_result && busy);
    assign wr_ok     = s_valid && s_write && hit;
    assign start     = wr_ok && (off == OFS_CTRL) && s_wdata[0] && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_a    <= '0;
            src_b    <= '0;
            len_q    <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            if (wr_ok && off == OFS_SRC_A) src_a <= AW'(s_wdata);
            if (wr_ok && off == OFS_SRC_B) src_b <= AW'(s_wdata);
            if (wr_ok && off == OFS_LEN)   len_q <= s_wdata;
            if (start)  done_q <= 1'b0;
            if (finish) begin
                done_q   <= 1'b1;
                result_q <= acc;
            end
        end
    end

    always_comb begin
        s_rdata = '0;
        if (hit) begin
            case (off)
                OFS_RESULT: s_rdata = result_q;
                OFS_CTRL:   s_rdata = {{(DW-2){1'b0}}, done_q, busy};
                OFS_SRC_A:  s_rdata = DW'(src_a);
                OFS_SRC_B:  s_rdata = DW'(src_b);
                OFS_LEN:    s_rdata = len_q;
                default:    s_rdata = '0;
            endcase
        end
    end

    dotp_fetch #(.AW(AW), .DW(DW), .CW(DW)) u_fetch (
        .clk(clk), .rst_n(rst_n), .start(start),
        .base_a(src_a), .base_b(src_b), .count(len_q),
        .m_valid(m_valid), .m_addr(m_addr), .m_ready(m_ready), .m_rdata(m_rdata),
        .pair_valid(pair_valid), .pair_a(pair_a), .pair_b(pair_b),
        .pipe_busy(pipe_busy), .busy(busy), .finish(finish)
    );

    dotp_mac #(.DW(DW)) u_mac (
        .clk(clk), .rst_n(rst_n), .clear(start),
        .in_valid(pair_valid), .in_a(pair_a), .in_b(pair_b),
        .acc(acc), .busy(pipe_busy)
    );

    // R6: the stored result does not move while a job runs
    p_result_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !finish |=> $stable(result_q));
    // R6: an idle block never stalls the slave port
    p_idle_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> s_ready);
    // R8: a launch clears done and raises busy
    p_launch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy && !done_q);
endmodule

// File: tb/dotp_accel_test.sv
module dotp_accel_test;
    localparam int PERIOD = 10;
    localparam logic [31:0] WB = 32'hF000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0, s_write = 1'b0;
    logic [31:0] s_addr = '0, s_wdata = '0;
    logic        s_ready;
    logic [31:0] s_rdata;
    logic        m_valid, m_ready;
    logic [31:0] m_addr, m_rdata;
    logic        mem_rdy = 1'b1;
    logic        stall_en = 1'b0;
    logic [31:0] mem [0:1023];

    int n_chk = 0, n_bad = 0;
    int acc_cnt = 0, ord_err = 0;
    int ex_ba = 0, ex_bb = 0, ex_i = 0;
    logic ex_ph = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    assign m_ready = mem_rdy;
    assign m_rdata = mem[m_addr[11:2]];

    dotp_accel uut (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_write(s_write),
        .s_addr(s_addr), .s_wdata(s_wdata), .s_ready(s_ready), .s_rdata(s_rdata),
        .m_valid(m_valid), .m_addr(m_addr), .m_ready(m_ready), .m_rdata(m_rdata)
    );

    always @(negedge clk) mem_rdy <= stall_en ? (($urandom % 3) != 0) : 1'b1;

    // expected fetch order tracker (R4)
    always @(posedge clk) begin
        if (m_valid && m_ready) begin
            acc_cnt++;
            if (m_addr !== 32'((ex_ph ? ex_bb : ex_ba) + 4 * ex_i)) ord_err++;
            if (ex_ph) ex_i++;
            ex_ph = !ex_ph;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [31:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output int waited);
        logic r;
        @(negedge clk);
        s_valid = 1'b1; s_write = wr; s_addr = addr; s_wdata = wd;
        waited = 0;
        forever begin
            #1;
            r = s_ready;
            rd = s_rdata;
            @(posedge clk);
            waited++;
            if (r) break;
            @(negedge clk);
        end
        #1;
        s_valid = 1'b0;
    endtask

    task automatic wr32(input logic [4:0] o, input logic [31:0] d);
        logic [31:0] rd; int w;
        xfer(1'b1, WB + 32'(o), d, rd, w);
    endtask

    task automatic rd32(input logic [4:0] o, output logic [31:0] d, output int w);
        xfer(1'b0, WB + 32'(o), 32'h0, d, w);
    endtask

    function automatic logic [31:0] dot(input int ba, input int bb, input int n);
        logic [31:0] s = 0;
        for (int i = 0; i < n; i++) s = s + mem[ba + i] * mem[bb + i];
        return s;
    endfunction

    task automatic run_job(input int ba, input int bb, input int n, input logic stall);
        logic [31:0] r; int w;
        stall_en = stall;
        wr32(5'h0C, 32'(ba * 4));
        wr32(5'h10, 32'(bb * 4));
        wr32(5'h14, 32'(n));
        acc_cnt = 0; ord_err = 0; ex_ba = ba * 4; ex_bb = bb * 4; ex_i = 0; ex_ph = 1'b0;
        wr32(5'h08, 32'h1);
        rd32(5'h00, r, w);
        chk("R3 sum", r, dot(ba, bb, n));
        chk("R4 order errors", 32'(ord_err), 0);
        chk("R4 access count", 32'(acc_cnt), 32'(2 * n));
        if (!stall) chk("R5 latency bound met", 32'(w <= 2 * n + 4), 1);
        rd32(5'h08, r, w);
        chk("R8 done after job", r, 32'h2);
        stall_en = 1'b0;
    endtask

    initial begin
        logic [31:0] r; int w; int seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < 1024; i++) mem[i] = $urandom;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10 reset state
        chk("R10 m_valid idle", {31'b0, m_valid}, 0);
        rd32(5'h08, r, w); chk("R10 status", r, 0);
        rd32(5'h00, r, w); chk("R10 result", r, 0);

        // R2 control write with bit0 clear launches nothing
        wr32(5'h08, 32'h2);
        rd32(5'h08, r, w); chk("R2 no launch", r, 0);

        // R1 argument readback and unmapped offset
        wr32(5'h0C, 32'h0000_0123);
        wr32(5'h10, 32'h0000_0456);
        wr32(5'h14, 32'h0000_0789);
        wr32(5'h04, 32'hDEAD_BEEF);
        rd32(5'h0C, r, w); chk("R1 arg A", r, 32'h123);
        rd32(5'h10, r, w); chk("R1 arg B", r, 32'h456);
        rd32(5'h14, r, w); chk("R1 count", r, 32'h789);
        rd32(5'h04, r, w); chk("R1 unmapped", r, 0);

        // R3 wrap with signed extremes
        mem[10] = 32'h7FFF_FFFF; mem[11] = 32'h8000_0000; mem[12] = 32'hFFFF_FFFF;
        mem[600] = 32'h0000_0002; mem[601] = 32'hFFFF_FFFF; mem[602] = 32'h7FFF_FFFF;
        run_job(10, 600, 3, 1'b0);
        chk("R3 extreme value", dot(10, 600, 3), 32'hFFFF_FFFE + 32'h8000_0000 + 32'h8000_0001);

        // R6 idle read returns at once with last result
        rd32(5'h00, r, w);
        chk("R6 idle read one cycle", 32'(w), 1);
        chk("R6 idle read value", r, dot(10, 600, 3));

        // R7 zero-length job clears the result and fetches nothing
        run_job(20, 700, 0, 1'b0);

        // R8/R9: busy bit, done cleared by launch, writes in mid-job ignored
        wr32(5'h0C, 32'(40 * 4));
        wr32(5'h10, 32'(520 * 4));
        wr32(5'h14, 32'd30);
        acc_cnt = 0; ord_err = 0; ex_ba = 160; ex_bb = 2080; ex_i = 0; ex_ph = 1'b0;
        wr32(5'h08, 32'h1);
        rd32(5'h08, r, w); chk("R8 busy and done cleared", r, 32'h1);
        wr32(5'h14, 32'd3);
        wr32(5'h08, 32'h1);
        rd32(5'h00, r, w);
        chk("R6 stalled read waited", 32'(w > 1), 1);
        chk("R9 mid-job launch ignored", r, dot(40, 520, 30));
        chk("R9 access count", 32'(acc_cnt), 60);

        // random jobs, with and without memory stalls (R3 R4 R5)
        for (int j = 0; j < 24; j++) begin
            run_job($urandom % 200, 512 + ($urandom % 200), $urandom % 41, 1'(j % 2));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule